// File: doc/BRIEF.md
# Alternating-buffer firmware download port

This block sits on the device side of a configuration register window and receives a firmware image from a host, one 32-bit dword at a time. The host writes dwords into two data registers in turn and signals each one through a per-register handshake bit in a 16-bit control/status register. The block moves every committed dword into an instruction RAM through a write port, at word addresses counting up from zero.

The host opens a download by setting the enable bit. It loads the first two dwords and raises both handshake bits in one write. After that it alternates: it waits for the handshake bit of a register to read 0, refills that register, and raises that bit alone. Clearing the enable bit closes the download. The block then reports success or error in a 3-bit result field. After a successful download it sets a lock bit, which blocks any further download until the next reset.

Top module: `fw_dl_port`

## Requirements
- R1: After reset the control/status register reads 0x0000, both data registers read 0, and the RAM write enable stays low.
- R2: The control/status register sits at offset 0xF4, with enable at bit 0, lock at bit 1, result at bits 6:4, the handshake bit of data register 0 at bit 8 and that of data register 1 at bit 9. Every other bit reads 0. Data register 0 sits at 0xF8 and data register 1 at 0xFC. Reads are combinational from the offset.
- R3: A 32-bit write (`req_wide`=1) to a data register stores the full dword. A 16-bit write (`req_wide`=0) to a data register is ignored. The control/status register accepts either size and uses the low 16 bits.
- R4: Dwords are committed strictly in index order, alternating between register 0 and register 1 and starting with register 0. A commit drives `ram_we` in the cycle right after the write that raised its handshake bit. When both bits are raised, the second dword follows one cycle later. A raised bit whose register is not next in order waits.
- R5: The first dword after an enable goes to RAM address 0, and each later commit goes to the previous address plus one.
- R6: Once the block has consumed a data register, it clears that register's handshake bit in the cycle after the commit. Writing 0 to a handshake bit has no effect. Handshake bits written while enable is 0 are ignored.
- R7: Clearing enable after at least one dword was committed, with no handshake bit pending and no overflow, sets the result to 3'b001 and sets lock.
- R8: While lock is 1, a write that sets enable leaves enable at 0. Only reset clears lock.
- R9: A commit attempted after 2**AW dwords have already been written does not write the RAM and sets the result to 3'b010 at once.
- R10: Clearing enable with a handshake bit still pending, or with no dword committed, sets the result to 3'b010, clears the pending bits and leaves lock at 0.
- R11: A 0-to-1 change of enable sets the result to 3'b000 and restarts the address at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, power-on |
| req_valid | input | 1 | Host access strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wide | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `req_addr` |
| ram_we | output | 1 | Instruction RAM write enable |
| ram_addr | output | AW | Instruction RAM word address |
| ram_wdata | output | 32 | Instruction RAM write data |

## Verification
A register write takes effect at the clock edge that captures it. Register reads are combinational, so the bench samples them one time unit after the falling edge that follows the write. A RAM commit appears in the cycle after the control write that raised its handshake bit, and a paired second commit appears one cycle later. The bench therefore samples `ram_we` on falling edges, between the rising edges that move the commit state. The scoreboard expects every commit in index order and flags any write it did not predict. Result and lock are read one cycle after the closing write. An overflow result is read two cycles after the control write that triggers it.

// File: rtl/fw_dl_pkg.sv
package fw_dl_pkg;
  localparam logic [7:0] OFS_CSR = 8'hF4;
  localparam logic [7:0] OFS_BUF0 = 8'hF8;
  localparam int BIT_EN = 0;
  localparam int BIT_LOCK = 1;
  localparam int BIT_RES = 4;
  localparam int BIT_SET = 8;

  typedef enum logic [2:0] {
    RES_IDLE = 3'b000,
    RES_OK   = 3'b001,
    RES_ERR  = 3'b010
  } res_e;

  function automatic logic [7:0] buf_ofs(input int idx);
    buf_ofs = OFS_BUF0 + 8'(idx * 4);
  endfunction

  function automatic res_e close_result(input logic had_err, input logic pend,
                                        input logic any_word);
    close_result = (had_err || pend || !any_word) ? RES_ERR : RES_OK;
  endfunction

  function automatic logic [15:0] csr_word(input logic en, input logic lock,
                                           input res_e res, input logic [1:0] setb);
    logic [15:0] w;
    w = '0;
    w[BIT_EN] = en;
    w[BIT_LOCK] = lock;
    w[BIT_RES +: 3] = res;
    w[BIT_SET +: 2] = setb;
    csr_word = w;
  endfunction
endpackage

// File: rtl/fw_dl_databuf.sv
module fw_dl_databuf
  import fw_dl_pkg::*;
#(
  parameter int DW = 32,
  parameter int NBUF = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_wide,
  input  logic [7:0]               req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic [NBUF-1:0][DW-1:0]  bufs
);
  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic hit;
    assign hit = req_valid && req_write && req_wide && (req_addr == buf_ofs(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bufs[g] <= '0;
      else if (hit) bufs[g] <= req_wdata;
    end
  end
endmodule

// File: rtl/fw_dl_commit.sv
module fw_dl_commit #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              stop,
  input  logic [1:0]        set_req,
  input  logic [1:0][DW-1:0] bufs,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic [1:0]        set_q,
  output logic              ovf_evt,
  output logic              words_any
);
  localparam logic [AW:0] CNT_ONE = 1;

  logic          idx;
  logic [AW:0]   cnt;
  logic          fire;
  logic          full;
  logic [1:0]    clr;

  assign fire      = en && set_q[idx];
  assign full      = cnt[AW];
  assign ram_we    = fire && !full;
  assign ovf_evt   = fire && full;
  assign ram_addr  = cnt[AW-1:0];
  assign ram_wdata = bufs[idx];
  assign words_any = (cnt != '0);
  assign clr       = fire ? (2'b01 << idx) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      idx   <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      set_q <= '0;
      idx   <= 1'b0;
      cnt   <= '0;
    end else begin
      if (stop) set_q <= '0;
      else      set_q <= (set_q & ~clr) | set_req;
      if (fire) begin
        idx <= ~idx;
        if (!full) cnt <= cnt + CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/fw_dl_port.sv
module fw_dl_port
  import fw_dl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [7:0]    req_addr,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rd_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [31:0]   ram_wdata
);
  localparam int DW = 32;

  logic           en_q;
  logic           lock_q;
  res_e           result_q;
  logic [1:0]     set_q;
  logic [1:0][DW-1:0] bufs;
  logic           csr_wr;
  logic           start;
  logic           stop;
  logic [1:0]     set_req;
  logic           ovf_evt;
  logic           words_any;
  res_e           closing;

  assign csr_wr  = req_valid && req_write && (req_addr == OFS_CSR);
  assign start   = csr_wr && req_wdata[BIT_EN] && !en_q && !lock_q;
  assign stop    = csr_wr && !req_wdata[BIT_EN] && en_q;
  assign set_req = (csr_wr && en_q) ? req_wdata[BIT_SET +: 2] : 2'b00;
  assign closing = close_result(result_q == RES_ERR || ovf_evt, |set_q, words_any);

  fw_dl_databuf #(.DW(DW), .NBUF(2)) u_buf (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata), .bufs(bufs)
  );

  fw_dl_commit #(.DW(DW), .AW(AW)) u_commit (
    .clk(clk), .rst_n(rst_n), .en(en_q), .start(start), .stop(stop),
    .set_req(set_req), .bufs(bufs), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .set_q(set_q), .ovf_evt(ovf_evt), .words_any(words_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      lock_q   <= 1'b0;
      result_q <= RES_IDLE;
    end else begin
      if (start) begin
        en_q     <= 1'b1;
        result_q <= RES_IDLE;
      end else if (stop) begin
        en_q     <= 1'b0;
        result_q <= closing;
        if (closing == RES_OK) lock_q <= 1'b1;
      end else if (ovf_evt) begin
        result_q <= RES_ERR;
      end
    end
  end

  always_comb begin
    if (req_addr == OFS_CSR)          rd_data = {16'h0, csr_word(en_q, lock_q, result_q, set_q)};
    else if (req_addr == buf_ofs(0))  rd_data = bufs[0];
    else if (req_addr == buf_ofs(1))  rd_data = bufs[1];
    else                              rd_data = '0;
  end
endmodule

// File: rtl/fw_dl_port_chk.sv
module fw_dl_port_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          lock,
  input logic [2:0]    result,
  input logic          start,
  input logic          csr_wr,
  input logic          wr_en_bit,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [1:0]    set_q
);
  localparam logic [AW-1:0] ADDR_ONE = 1;

  // R8
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n) lock |=> lock);
  // R8
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !en && csr_wr && wr_en_bit) |=> !en);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (ram_addr == $past(ram_addr) + ADDR_ONE));
  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (en && result == 3'b000 && ram_addr == '0));
  // R7
  ok_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result == 3'b001) |-> lock);
  // R4
  commit_en_chk: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> en);
  // R6
  set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |-> (set_q == 2'b00));
endmodule

bind fw_dl_port fw_dl_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .lock(lock_q), .result(result_q),
  .start(start), .csr_wr(csr_wr), .wr_en_bit(req_wdata[0]), .ram_we(ram_we),
  .ram_addr(ram_addr), .set_q(set_q)
);

// File: tb/fw_dl_port_bench.sv
module fw_dl_port_bench;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] A_CSR = 8'hF4;
  localparam logic [7:0] A_D0 = 8'hF8;
  localparam logic [7:0] A_D1 = 8'hFC;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_wide = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] rd_data;
  logic ram_we;
  logic [AW-1:0] ram_addr;
  logic [31:0] ram_wdata;

  int checks = 0, fails = 0;
  logic [AW+31:0] expq[$];
  logic [31:0] rv;

  always #(CLK_P/2) clk = ~clk;

  fw_dl_port #(.AW(AW)) u_fw_dl_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: RAM writes checked against the scoreboard (R4, R5)
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R4 actual=unexpected write addr %0d data %h expected=no write", ram_addr, ram_wdata);
      end else begin
        logic [AW+31:0] e;
        e = expq.pop_front();
        if ({ram_addr, ram_wdata} !== e) begin
          fails++;
          $display("FAIL R5 actual=%h expected=%h", {ram_addr, ram_wdata}, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic wide);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_wide = wide;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    req_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 50 && expq.size() != 0; k++) @(negedge clk);
    @(negedge clk);
    check("R4 drain", 32'(expq.size()), 32'd0);
  endtask

  function automatic logic [31:0] word_of(input int i);
    word_of = {16'(i) ^ 16'h5A3C, ~16'(i)};
  endfunction

  task automatic load_words(input int n);
    for (int i = 0; i < n; i++) begin
      int b;
      b = i & 1;
      if (i >= 2) begin
        for (int k = 0; k < 40; k++) begin
          bus_rd(A_CSR, rv);
          if (rv[8+b] == 1'b0) break;
          @(negedge clk);
        end
      end
      bus_wr(b ? A_D1 : A_D0, word_of(i), 1'b1);
      if (i < DEPTH) expq.push_back({AW'(i), word_of(i)});
      if (i == 1) bus_wr(A_CSR, 32'h0301, 1'b0);
      else if (i >= 2) bus_wr(A_CSR, 32'h0001 | (32'h1 << (8 + b)), 1'b0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    bus_rd(A_CSR, rv); check("R1 csr", rv, 32'h0);
    bus_rd(A_D0, rv);  check("R1 data0", rv, 32'h0);
    check("R1 ram_we", 32'(ram_we), 32'h0);

    // R3 write sizes
    bus_wr(A_D0, 32'h1234_5678, 1'b1);
    bus_wr(A_D0, 32'h0000_FFFF, 1'b0);
    bus_rd(A_D0, rv); check("R3 16-bit ignored", rv, 32'h1234_5678);
    bus_wr(A_D1, 32'hCAFE_0001, 1'b1);
    bus_rd(A_D1, rv); check("R3 data1", rv, 32'hCAFE_0001);

    // R6 handshake bits ignored while disabled
    bus_wr(A_CSR, 32'h0300, 1'b0);
    @(negedge clk);
    bus_rd(A_CSR, rv); check("R6 disabled set", rv, 32'h0);

    // R2 R11 enable
    bus_wr(A_CSR, 32'h0001, 1'b0);
    bus_rd(A_CSR, rv); check("R2 R11 enable", rv, 32'h0001);
    load_words(5);
    wait_drain();
    bus_rd(A_CSR, rv); check("R6 bits cleared", rv, 32'h0001);
    bus_wr(A_CSR, 32'h0000, 1'b0);
    bus_rd(A_CSR, rv); check("R7 success and lock", rv, 32'h0012);

    // R8 lock blocks enable
    bus_wr(A_CSR, 32'h0001, 1'b0);
    bus_rd(A_CSR, rv); check("R8 enable blocked", rv, 32'h0012);
    do_reset();
    bus_rd(A_CSR, rv); check("R8 reset clears lock", rv, 32'h0);

    // R10 no words committed
    bus_wr(A_CSR, 32'h0001, 1'b0);
    bus_wr(A_CSR, 32'h0000, 1'b0);
    bus_rd(A_CSR, rv); check("R10 empty close", rv, 32'h0020);

    // R4 ordering: register 1 raised first waits
    bus_wr(A_CSR, 32'h0001, 1'b1);
    bus_wr(A_D0, 32'hAAAA_0000, 1'b1);
    bus_wr(A_D1, 32'hBBBB_1111, 1'b1);
    bus_wr(A_CSR, 32'h0201, 1'b0);
    repeat (3) @(negedge clk);
    bus_rd(A_CSR, rv); check("R4 out-of-order waits", rv, 32'h0201);
    bus_wr(A_CSR, 32'h0001, 1'b0);
    bus_rd(A_CSR, rv); check("R6 zero write no effect", rv, 32'h0201);
    expq.push_back({AW'(0), 32'hAAAA_0000});
    expq.push_back({AW'(1), 32'hBBBB_1111});
    bus_wr(A_CSR, 32'h0101, 1'b0);
    check("R4 commit cycle", {31'h0, ram_we}, 32'h1);
    wait_drain();
    bus_rd(A_CSR, rv); check("R4 both consumed", rv, 32'h0001);
    bus_wr(A_CSR, 32'h0000, 1'b0);
    bus_rd(A_CSR, rv); check("R7 second success", rv, 32'h0012);
    do_reset();

    // R10 pending at close
    bus_wr(A_CSR, 32'h0001, 1'b0);
    bus_wr(A_D0, 32'h0BAD_0BAD, 1'b1);
    bus_wr(A_CSR, 32'h0201, 1'b0);
    bus_wr(A_CSR, 32'h0000, 1'b0);
    bus_rd(A_CSR, rv); check("R10 pending close", rv, 32'h0020);

    // R9 overflow
    bus_wr(A_CSR, 32'h0001, 1'b0);
    bus_rd(A_CSR, rv); check("R11 result reset", rv, 32'h0001);
    load_words(DEPTH + 1);
    @(negedge clk);
    wait_drain();
    bus_rd(A_CSR, rv); check("R9 overflow error", rv, 32'h0021);
    bus_wr(A_CSR, 32'h0000, 1'b0);
    bus_rd(A_CSR, rv); check("R9 error close", rv, 32'h0020);

    // R11 R5 restart at address 0
    bus_wr(A_CSR, 32'h0001, 1'b0);
    bus_rd(A_CSR, rv); check("R11 re-enable", rv, 32'h0001);
    load_words(2);
    wait_drain();
    bus_wr(A_CSR, 32'h0000, 1'b0);
    bus_rd(A_CSR, rv); check("R7 after restart", rv, 32'h0012);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule